// File: doc/BRIEF.md
# Firmware Image Download Port

This block is a register-bus slave through which a host processor loads a firmware image into the instruction memory of an embedded controller, one 32-bit word per transfer. The host raises a download-enable bit, then for each word writes the word into a data register and sets a "word ready" bit in the control register. The block moves the word into the firmware RAM at a rising write pointer and drops the ready bit by itself, which tells the host that the next word may be sent.

When the host clears the enable bit, the block judges the received image. The image passes if at least one word arrived, no word fell past the end of the RAM, and the 32-bit wrapping sum of all stored words is zero (the image's last word is chosen to make it so). The outcome is shown as two read-only status bits, pass and fail, which the host polls. Raising enable again starts a fresh download with cleared status.

Top module: `fwload_port`

## Requirements
- R1: Byte address 0x250 is the control/status register (bit 0 enable, read/write; bit 4 pass, read-only; bit 5 fail, read-only; bit 8 word ready) and 0x258 the data register, which reads back the last stored data word; any other address reads zero, and all of them read zero after reset.
- R2: A control write carrying bits 8 and 0 both set while enable is already 1 sets the word-ready bit, which reads 1 for exactly ACCEPT_LAT cycles and then clears by itself.
- R3: Each accepted word drives ram_we high for one cycle, the last cycle in which word ready is 1, with ram_wdata equal to the data register contents.
- R4: The RAM address of the first word after enable rises is 0 and rises by one for each stored word.
- R5: While enable is 0, data-register writes leave the data register unchanged, and a control write with bit 8 set neither sets word ready nor causes a RAM write.
- R6: A data-register write while word ready is 1 is ignored; the pending word is stored unchanged.
- R7: One cycle after the control write that clears enable, exactly one of pass (bit 4) or fail (bit 5) reads 1: pass when the stored word count is nonzero, no word overflowed and the wrapping 32-bit sum of stored words is zero; fail otherwise. Neither is 1 while enable is 1.
- R8: A control write that raises enable clears pass, fail, the write pointer and the running sum.
- R9: A word accepted after DEPTH words were stored produces no RAM write, still clears word ready on schedule, and makes the download fail.
- R10: Clearing enable before the commit cycle of a pending word discards it (no RAM write, word ready cleared); clearing enable in the commit cycle itself lets the word be stored and counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ram_we | output | 1 | Firmware RAM write strobe |
| ram_addr | output | $clog2(DEPTH) | Firmware RAM word address |
| ram_wdata | output | 32 | Firmware RAM write data |

## Verification
The host's enable-clear write can land in the same cycle as the commit of a pending word, so word storage and the start of the image check collide. The bench provokes this twice with a single zero word: once clearing enable one cycle before the commit cycle, once in the commit cycle itself. The first must show no RAM write and a fail verdict (empty image); the second must show the RAM write and a pass verdict, proving the commit and its count reach the check.

// File: rtl/fwload_pkg.sv
package fwload_pkg;

    localparam int WORD_W = 32;

    localparam int EN_BIT   = 0;
    localparam int PASS_BIT = 4;
    localparam int FAIL_BIT = 5;
    localparam int RDY_BIT  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHECK,
        ST_DONE
    } dl_state_e;

    typedef struct packed {
        logic              ctrl_wr;
        logic              data_wr;
        logic              en_val;
        logic              rdy_req;
        logic [WORD_W-1:0] wdata;
    } bus_cmd_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic en,
        input logic pass,
        input logic fail,
        input logic rdy
    );
        logic [WORD_W-1:0] v;
        v           = '0;
        v[EN_BIT]   = en;
        v[PASS_BIT] = pass;
        v[FAIL_BIT] = fail;
        v[RDY_BIT]  = rdy;
        return v;
    endfunction

    function automatic logic image_ok(
        input logic              nonempty,
        input logic              overflow,
        input logic [WORD_W-1:0] sum
    );
        return nonempty && !overflow && (sum == '0);
    endfunction

endpackage

// File: rtl/fwload_decode.sv
module fwload_decode
    import fwload_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CTRL_OFS = 'h250,
    parameter int DATA_OFS = 'h258
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              sel_ctrl,
    output logic              sel_data,
    output bus_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

    always_comb begin
        sel_ctrl    = (bus_addr == CTRL_A);
        sel_data    = (bus_addr == DATA_A);
        cmd.ctrl_wr = bus_we && sel_ctrl;
        cmd.data_wr = bus_we && sel_data;
        cmd.en_val  = bus_wdata[EN_BIT];
        cmd.rdy_req = bus_wdata[RDY_BIT];
        cmd.wdata   = bus_wdata;
    end

endmodule

// File: rtl/fwload_accept.sv
module fwload_accept
    import fwload_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int ACCEPT_LAT = 2,
    parameter int PTR_W      = $clog2(DEPTH + 1),
    parameter int AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_q,
    input  logic              start,
    input  logic              drop,
    input  bus_cmd_t          cmd,
    output logic              rdy_flag,
    output logic [WORD_W-1:0] data_q,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic [PTR_W-1:0]  wptr,
    output logic [WORD_W-1:0] sum_q,
    output logic              ovf_q
);

    localparam int LAT_W = $clog2(ACCEPT_LAT) + 1;
    localparam logic [LAT_W-1:0] LAST_LAT = LAT_W'(ACCEPT_LAT - 1);
    localparam logic [PTR_W-1:0] FULL_PTR = PTR_W'(DEPTH);

    logic [LAT_W-1:0] lat_cnt;
    logic             commit;
    logic             full;
    logic             new_word;

    always_comb begin
        full      = (wptr == FULL_PTR);
        commit    = rdy_flag && (lat_cnt == LAST_LAT);
        ram_we    = commit && !full;
        ram_addr  = wptr[AW-1:0];
        ram_wdata = data_q;
        new_word  = cmd.ctrl_wr && cmd.rdy_req && cmd.en_val && en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_flag <= 1'b0;
            lat_cnt  <= '0;
            data_q   <= '0;
            wptr     <= '0;
            sum_q    <= '0;
            ovf_q    <= 1'b0;
        end else if (start) begin
            rdy_flag <= 1'b0;
            lat_cnt  <= '0;
            wptr     <= '0;
            sum_q    <= '0;
            ovf_q    <= 1'b0;
        end else if (rdy_flag) begin
            if (commit) begin
                rdy_flag <= 1'b0;
                lat_cnt  <= '0;
                if (full) begin
                    ovf_q <= 1'b1;
                end else begin
                    wptr  <= wptr + 1'b1;
                    sum_q <= sum_q + data_q;
                end
            end else if (drop) begin
                rdy_flag <= 1'b0;
                lat_cnt  <= '0;
            end else begin
                lat_cnt <= lat_cnt + 1'b1;
            end
        end else begin
            if (cmd.data_wr && en_q) begin
                data_q <= cmd.wdata;
            end
            if (new_word) begin
                rdy_flag <= 1'b1;
                lat_cnt  <= '0;
            end
        end
    end

endmodule

// File: rtl/fwload_verdict.sv
module fwload_verdict
    import fwload_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              en_val,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [WORD_W-1:0] sum_q,
    input  logic              ovf_q,
    output logic              en_q,
    output logic              start,
    output logic              drop,
    output logic              pass_q,
    output logic              fail_q
);

    dl_state_e state_q;
    logic      verdict;

    always_comb begin
        start   = ctrl_wr && en_val && !en_q;
        drop    = ctrl_wr && !en_val && en_q;
        verdict = image_ok(wptr != '0, ovf_q, sum_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            state_q <= ST_IDLE;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q <= en_val;
            end
            if (start) begin
                state_q <= ST_LOAD;
                pass_q  <= 1'b0;
                fail_q  <= 1'b0;
            end else begin
                case (state_q)
                    ST_LOAD:  if (drop) state_q <= ST_CHECK;
                    ST_CHECK: begin
                        state_q <= ST_DONE;
                        pass_q  <= verdict;
                        fail_q  <= !verdict;
                    end
                    default:  state_q <= state_q;
                endcase
            end
        end
    end

endmodule

// File: rtl/fwload_port.sv
module fwload_port
    import fwload_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int CTRL_OFS   = 'h250,
    parameter int DATA_OFS   = 'h258,
    parameter int DEPTH      = 64,
    parameter int ACCEPT_LAT = 2,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [31:0]       ram_wdata
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    bus_cmd_t          cmd;
    logic              sel_ctrl;
    logic              sel_data;
    logic              en_q;
    logic              start;
    logic              drop;
    logic              rdy_flag;
    logic [WORD_W-1:0] data_q;
    logic [PTR_W-1:0]  wptr;
    logic [WORD_W-1:0] sum_q;
    logic              ovf_q;
    logic              pass_q;
    logic              fail_q;

    fwload_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .DATA_OFS (DATA_OFS)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .sel_ctrl  (sel_ctrl),
        .sel_data  (sel_data),
        .cmd       (cmd)
    );

    fwload_accept #(
        .DEPTH      (DEPTH),
        .ACCEPT_LAT (ACCEPT_LAT),
        .PTR_W      (PTR_W),
        .AW         (AW)
    ) u_accept (
        .clk       (clk),
        .rst       (rst),
        .en_q      (en_q),
        .start     (start),
        .drop      (drop),
        .cmd       (cmd),
        .rdy_flag  (rdy_flag),
        .data_q    (data_q),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .wptr      (wptr),
        .sum_q     (sum_q),
        .ovf_q     (ovf_q)
    );

    fwload_verdict #(
        .PTR_W (PTR_W)
    ) u_verdict (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (cmd.ctrl_wr),
        .en_val  (cmd.en_val),
        .wptr    (wptr),
        .sum_q   (sum_q),
        .ovf_q   (ovf_q),
        .en_q    (en_q),
        .start   (start),
        .drop    (drop),
        .pass_q  (pass_q),
        .fail_q  (fail_q)
    );

    always_comb begin
        if (sel_ctrl) begin
            bus_rdata = pack_status(en_q, pass_q, fail_q, rdy_flag);
        end else if (sel_data) begin
            bus_rdata = data_q;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/fwload_port_chk.sv
module fwload_port_chk #(
    parameter int ACCEPT_LAT = 2,
    parameter int AW         = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          en_q,
    input logic          rdy_flag,
    input logic          pass_q,
    input logic          fail_q,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (rdy_flag) begin
            hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    assert_ready_window_R2: assert property (@(posedge clk) disable iff (rst)
        rdy_flag |-> (hi_cnt < 16'(ACCEPT_LAT)));

    assert_write_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (en_q && rdy_flag));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (ram_addr == AW'($past(ram_addr) + 1'b1)));

    assert_no_ready_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !rdy_flag);

    assert_one_verdict_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass_q, fail_q}));

    assert_verdict_only_off_R7: assert property (@(posedge clk) disable iff (rst)
        (pass_q || fail_q) |-> !en_q);

    assert_clean_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> (!pass_q && !fail_q && ram_addr == '0));

endmodule

bind fwload_port fwload_port_chk #(
    .ACCEPT_LAT (ACCEPT_LAT),
    .AW         (AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_q     (en_q),
    .rdy_flag (rdy_flag),
    .pass_q   (pass_q),
    .fail_q   (fail_q),
    .ram_we   (ram_we),
    .ram_addr (ram_addr)
);

// File: tb/fwload_port_tb.sv
`timescale 1ns/100ps
module fwload_port_tb;

    localparam int ADDR_W = 12;
    localparam int DEPTH  = 16;
    localparam int AW     = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] A_CTRL = 12'h250;
    localparam logic [ADDR_W-1:0] A_DATA = 12'h258;
    localparam logic [ADDR_W-1:0] A_HOLE = 12'h254;

    typedef struct packed {
        int          nwords;
        logic [31:0] seed;
        logic        corrupt;
        logic        exp_pass;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{4,     32'h1234_5678, 1'b0, 1'b1},
        '{1,     32'h0000_0000, 1'b0, 1'b1},
        '{5,     32'hCAFE_0001, 1'b1, 1'b0},
        '{0,     32'h0000_0000, 1'b0, 1'b0},
        '{DEPTH, 32'hA5A5_0F0F, 1'b0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              ram_we;
    logic [AW-1:0]     ram_addr;
    logic [31:0]       ram_wdata;

    int errors = 0;
    int checks = 0;
    int we_seen = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (!rst && ram_we) we_seen <= we_seen + 1;

    fwload_port #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ACCEPT_LAT(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        tick();
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.4;
        d = bus_rdata;
    endtask

    task automatic send_word(input logic [31:0] w, input int exp_addr, input logic exp_we);
        logic [31:0] rd;
        bus_write(A_DATA, w);
        bus_write(A_CTRL, 32'h101);
        bus_read(A_CTRL, rd);
        chk("R2 ready set", {31'b0, rd[8]}, 32'd1);
        tick();
        bus_read(A_CTRL, rd);
        chk("R2 ready held", {31'b0, rd[8]}, 32'd1);
        chk(exp_we ? "R3 ram write" : "R9 no write past end", {31'b0, ram_we}, {31'b0, exp_we});
        if (exp_we) begin
            chk("R4 ram address", {{(32-AW){1'b0}}, ram_addr}, 32'(exp_addr));
            chk("R3 ram data", ram_wdata, w);
        end
        tick();
        bus_read(A_CTRL, rd);
        chk(exp_we ? "R2 ready self-clear" : "R9 ready clears", {31'b0, rd[8]}, 32'd0);
    endtask

    task automatic finish_check(input logic exp_pass, input string tag);
        logic [31:0] rd;
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, rd);
        chk({tag, " no verdict yet"}, rd, 32'h0);
        tick();
        bus_read(A_CTRL, rd);
        chk({tag, " verdict"}, rd, exp_pass ? 32'h10 : 32'h20);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] sum;
        logic [31:0] w;
        int          base;

        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset values and register map
        bus_read(A_CTRL, rd);
        chk("R1 ctrl reset", rd, 32'h0);
        bus_read(A_DATA, rd);
        chk("R1 data reset", rd, 32'h0);
        chk("R1 no ram write at reset", {31'b0, ram_we}, 32'd0);

        // R5: writes while disabled are ignored
        bus_write(A_DATA, 32'hDEAD_BEEF);
        bus_read(A_DATA, rd);
        chk("R5 data ignored when off", rd, 32'h0);
        base = we_seen;
        bus_write(A_CTRL, 32'h100);
        bus_read(A_CTRL, rd);
        chk("R5 ready not set when off", rd, 32'h0);
        repeat (3) tick();
        chk("R5 no ram write when off", 32'(we_seen), 32'(base));

        // Vector table: R2 R3 R4 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            bus_write(A_CTRL, 32'h1);
            bus_read(A_CTRL, rd);
            chk("R8 status clear on enable", rd, 32'h1);
            sum = '0;
            for (int i = 0; i < VECS[v].nwords; i++) begin
                if (i == VECS[v].nwords - 1) begin
                    w = (32'h0 - sum) + {31'b0, VECS[v].corrupt};
                end else begin
                    w = VECS[v].seed ^ (32'(i + 1) * 32'h9E37_79B9);
                end
                sum = sum + w;
                send_word(w, i, 1'b1);
            end
            finish_check(VECS[v].exp_pass, "R7 table");
        end

        // R1: unused address reads zero, data register reads back
        bus_write(A_CTRL, 32'h1);
        bus_write(A_DATA, 32'h0BAD_F00D);
        bus_read(A_HOLE, rd);
        chk("R1 hole reads zero", rd, 32'h0);
        bus_read(A_DATA, rd);
        chk("R1 data readback", rd, 32'h0BAD_F00D);

        // R6: data write during pending word is ignored
        bus_write(A_DATA, 32'h0);
        bus_write(A_CTRL, 32'h101);
        bus_write(A_DATA, 32'h7777_7777);
        chk("R6 pending word kept", ram_wdata, 32'h0);
        chk("R6 commit happens", {31'b0, ram_we}, 32'd1);
        tick();
        bus_read(A_DATA, rd);
        chk("R6 data reg unchanged", rd, 32'h0);
        finish_check(1'b1, "R6 single zero word");

        // R10: disable before commit cycle drops the word
        bus_write(A_CTRL, 32'h1);
        bus_write(A_DATA, 32'h0);
        bus_write(A_CTRL, 32'h101);
        base = we_seen;
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, rd);
        chk("R10 ready dropped", rd, 32'h0);
        tick();
        bus_read(A_CTRL, rd);
        chk("R10 empty image fails", rd, 32'h20);
        chk("R10 no ram write", 32'(we_seen), 32'(base));

        // R10: disable in the commit cycle keeps the word
        bus_write(A_CTRL, 32'h1);
        bus_write(A_DATA, 32'h0);
        bus_write(A_CTRL, 32'h101);
        base = we_seen;
        tick();
        chk("R10 commit cycle write", {31'b0, ram_we}, 32'd1);
        finish_check(1'b1, "R10 commit kept");
        chk("R10 one ram write", 32'(we_seen), 32'(base + 1));

        // R9: overflow past DEPTH fails the image
        bus_write(A_CTRL, 32'h1);
        sum = '0;
        for (int i = 0; i < DEPTH; i++) begin
            w = (i == DEPTH - 1) ? (32'h0 - sum) : 32'(i * 7 + 3);
            sum = sum + w;
            send_word(w, i, 1'b1);
        end
        send_word(32'h0, 0, 1'b0);
        finish_check(1'b0, "R9 overflow");

        // R8: restart clears fail and pointer
        bus_write(A_CTRL, 32'h1);
        bus_read(A_CTRL, rd);
        chk("R8 fail cleared", rd, 32'h1);
        send_word(32'h0, 0, 1'b1);
        finish_check(1'b1, "R8 restart");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule